// File: doc/BRIEF.md
# Conditional Trap Evaluator

This block decides whether a conditional trap instruction should raise an exception. It takes two operands, a five-bit condition mask and a width select. It evaluates five relations between the operands in parallel: signed less-than, signed greater-than, equality, unsigned less-than and unsigned greater-than. Each relation is gated by its own mask bit. If any enabled relation holds, the block raises a trap request.

The width select chooses between two compare modes. In word mode only the low 32 bits of each operand take part, under 32-bit signed and unsigned rules. In doubleword mode all 64 bits are compared. Each valid strobe produces one registered result on the cycle after the strobe. A firing trap is presented as a single-cycle request together with the program-exception cause code for a trap.

Top module: `trap_eval`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `trap_req` is 0 and `trap_cause` is 0.
- R2: Mask bit 4 (value 0x10) enables a trap when A is less than B as signed numbers.
- R3: Mask bit 3 (value 0x08) enables a trap when A is greater than B as signed numbers.
- R4: Mask bit 2 (value 0x04) enables a trap when A equals B.
- R5: Mask bit 1 (value 0x02) enables a trap when A is less than B as unsigned numbers.
- R6: Mask bit 0 (value 0x01) enables a trap when A is greater than B as unsigned numbers.
- R7: The trap fires when at least one enabled relation holds. Enabled relations are ORed, never ANDed.
- R8: With `dword_mode` = 0, only bits 31:0 of each operand are compared, using 32-bit signed and unsigned rules. Bits 63:32 have no effect on the result.
- R9: With `dword_mode` = 1, all 64 bits of each operand are compared.
- R10: A mask of 0x00 never traps. A mask of 0x1F always traps.
- R11: `trap_req` reflects the operands sampled on a clock edge with `in_valid` = 1 and appears on the next cycle, for exactly one cycle per strobe. A cycle sampled with `in_valid` = 0 gives `trap_req` = 0 on the following cycle.
- R12: `trap_cause` equals 0x2 (the trap cause code) whenever `trap_req` is 1, and 0x0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and mask are valid this cycle |
| op_a | input | 64 | First operand (A) |
| op_b | input | 64 | Second operand (B) |
| cond_mask | input | 5 | Relation enable mask |
| dword_mode | input | 1 | 1 = 64-bit compare, 0 = 32-bit compare |
| trap_req | output | 1 | Registered single-cycle trap request |
| trap_cause | output | 4 | Program-exception cause code carried with the request |

## Verification
The assertions assume that all inputs are at known values on every sampling edge once reset is released. They also assume that `in_valid` may be held high on consecutive cycles, so back-to-back strobes must give back-to-back pulses rather than one merged pulse. The stimulus drives every input on the falling edge, so each input holds a defined value at every rising edge. It mixes strobed and idle cycles, and it chooses operands that land on the delicate cases: equal operands, operands whose low words match but whose upper words differ, and values that straddle the sign bit at bit 31 and at bit 63.

// File: rtl/trap_eval_pkg.sv
package trap_eval_pkg;
  localparam int MASK_W  = 5;
  localparam int CAUSE_W = 4;
  localparam logic [CAUSE_W-1:0] CAUSE_NONE = 4'h0;
  localparam logic [CAUSE_W-1:0] CAUSE_TRAP = 4'h2;

  // field order matches the mask bit positions, MSB first
  typedef struct packed {
    logic s_lt;
    logic s_gt;
    logic eq;
    logic u_lt;
    logic u_gt;
  } rel_t;
endpackage

// File: rtl/trap_rel_unit.sv
module trap_rel_unit
  import trap_eval_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              wide,
  output rel_t              rel
);
  localparam int DIFF_W = DATA_W + 1;

  logic [DATA_W-1:0] a_x, b_x;
  logic              msb_a, msb_b;
  logic [DIFF_W-1:0] diff;
  logic              borrow, zero, s_less;

  generate
    if (DATA_W > WORD_W) begin : g_narrow
      always_comb begin
        a_x   = wide ? a : {{(DATA_W-WORD_W){1'b0}}, a[WORD_W-1:0]};
        b_x   = wide ? b : {{(DATA_W-WORD_W){1'b0}}, b[WORD_W-1:0]};
        msb_a = wide ? a[DATA_W-1] : a[WORD_W-1];
        msb_b = wide ? b[DATA_W-1] : b[WORD_W-1];
      end
    end else begin : g_single
      always_comb begin
        a_x   = a;
        b_x   = b;
        msb_a = a[DATA_W-1] | (wide & 1'b0);
        msb_b = b[DATA_W-1];
      end
    end
  endgenerate

  // one shared subtractor serves all five relations
  always_comb begin
    diff   = {1'b0, a_x} - {1'b0, b_x};
    borrow = diff[DIFF_W-1];
    zero   = (diff[DATA_W-1:0] == '0);
    s_less = borrow ^ msb_a ^ msb_b;
    rel.u_lt = borrow;
    rel.u_gt = ~borrow & ~zero;
    rel.eq   = zero;
    rel.s_lt = s_less;
    rel.s_gt = ~s_less & ~zero;
  end
endmodule

// File: rtl/trap_mask_sel.sv
module trap_mask_sel
  import trap_eval_pkg::*;
(
  input  rel_t              rel,
  input  logic [MASK_W-1:0] mask,
  output logic              hit
);
  logic [MASK_W-1:0] gated;

  generate
    for (genvar i = 0; i < MASK_W; i++) begin : g_gate
      assign gated[i] = rel[i] & mask[i];
    end
  endgenerate

  assign hit = |gated;
endmodule

// File: rtl/trap_eval.sv
module trap_eval
  import trap_eval_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [DATA_W-1:0]   op_a,
  input  logic [DATA_W-1:0]   op_b,
  input  logic [MASK_W-1:0]   cond_mask,
  input  logic                dword_mode,
  output logic                trap_req,
  output logic [CAUSE_W-1:0]  trap_cause
);
  rel_t               rel;
  logic               hit;
  logic               req_q, req_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;

  trap_rel_unit #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_rel (
    .a    (op_a),
    .b    (op_b),
    .wide (dword_mode),
    .rel  (rel)
  );

  trap_mask_sel u_sel (
    .rel  (rel),
    .mask (cond_mask),
    .hit  (hit)
  );

  always_comb begin
    req_d   = in_valid & hit;
    cause_d = req_d ? CAUSE_TRAP : CAUSE_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      req_q   <= req_d;
      cause_q <= cause_d;
    end
  end

  assign trap_req   = req_q;
  assign trap_cause = cause_q;
endmodule

// File: rtl/trap_eval_chk.sv
module trap_eval_chk
  import trap_eval_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [DATA_W-1:0]  op_a,
  input logic [DATA_W-1:0]  op_b,
  input logic [MASK_W-1:0]  cond_mask,
  input logic               dword_mode,
  input logic               trap_req,
  input logic [CAUSE_W-1:0] trap_cause
);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !trap_req);

  assert_zero_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond_mask == '0) |=> !trap_req);

  assert_full_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond_mask == '1) |=> trap_req);

  assert_cause_on_R12: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> trap_cause == CAUSE_TRAP);

  assert_cause_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |-> trap_cause == CAUSE_NONE);

  assert_low_word_eq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dword_mode && cond_mask[2] &&
     op_a[WORD_W-1:0] == op_b[WORD_W-1:0]) |=> trap_req);

  assert_ulow_dword_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dword_mode && cond_mask[1] && op_a < op_b) |=> trap_req);

  assert_slow_dword_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dword_mode && cond_mask[4] && $signed(op_a) < $signed(op_b))
    |=> trap_req);
endmodule

bind trap_eval trap_eval_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .op_a       (op_a),
  .op_b       (op_b),
  .cond_mask  (cond_mask),
  .dword_mode (dword_mode),
  .trap_req   (trap_req),
  .trap_cause (trap_cause)
);

// File: tb/trap_eval_tb.sv
module trap_eval_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic [4:0]  cond_mask = '0;
  logic        dword_mode = 1'b0;
  logic        trap_req;
  logic [3:0]  trap_cause;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic   checking = 1'b0;
  logic   exp_req = 1'b0;
  string  cur_tag = "R11";
  string  exp_tag = "R1";

  always #10 clk = ~clk;

  trap_eval u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .cond_mask(cond_mask), .dword_mode(dword_mode),
    .trap_req(trap_req), .trap_cause(trap_cause)
  );

  function automatic bit ref_hit(logic [63:0] a, logic [63:0] b,
                                 logic [4:0] m, logic dw);
    longint          sa, sb;
    longint unsigned ua, ub;
    bit r;
    if (dw) begin
      sa = $signed(a); sb = $signed(b); ua = a; ub = b;
    end else begin
      sa = longint'($signed(a[31:0])); sb = longint'($signed(b[31:0]));
      ua = longint'(a[31:0]); ub = longint'(b[31:0]);
    end
    r = 0;
    if (m[4] && sa < sb) r = 1;
    if (m[3] && sa > sb) r = 1;
    if (m[2] && ua == ub) r = 1;
    if (m[1] && ua < ub) r = 1;
    if (m[0] && ua > ub) r = 1;
    return r;
  endfunction

  // reference model, advanced at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_req <= 1'b0;
      exp_tag <= "R1";
    end else begin
      exp_req <= in_valid && ref_hit(op_a, op_b, cond_mask, dword_mode);
      exp_tag <= cur_tag;
    end
  end

  // compare on every falling edge (R11 timing, R12 cause)
  always @(negedge clk) begin
    if (checking) begin
      checks++;
      if (trap_req !== exp_req) begin
        errors++;
        $display("FAIL %s trap_req actual=%b expected=%b", exp_tag, trap_req, exp_req);
      end
      checks++;
      if (trap_cause !== (exp_req ? 4'h2 : 4'h0)) begin
        errors++;
        $display("FAIL R12 trap_cause actual=%h expected=%h", trap_cause,
                 exp_req ? 4'h2 : 4'h0);
      end
    end
  end

  task automatic drive(input logic v, input logic [63:0] a, input logic [63:0] b,
                       input logic [4:0] m, input logic dw, input string tag);
    @(negedge clk);
    in_valid = v; op_a = a; op_b = b; cond_mask = m; dword_mode = dw;
    cur_tag = tag;
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    checks++;
    if (trap_req !== 1'b0 || trap_cause !== 4'h0) begin
      errors++;
      $display("FAIL R1 reset actual=%b/%h expected=0/0", trap_req, trap_cause);
    end
    rst_n = 1'b1;
    checking = 1'b1;
    // R2 / R5: -1 vs 1, signed less holds, unsigned less does not
    drive(1, '1, 64'd1, 5'h10, 1, "R2");
    drive(1, '1, 64'd1, 5'h02, 1, "R5");
    drive(1, 64'd1, '1, 5'h02, 1, "R5");
    // R3 / R6
    drive(1, 64'd7, 64'd3, 5'h08, 1, "R3");
    drive(1, 64'd1, '1, 5'h08, 1, "R3");
    drive(1, '1, 64'd1, 5'h01, 1, "R6");
    drive(1, 64'd3, 64'd7, 5'h01, 1, "R6");
    // R4
    drive(1, 64'h55AA, 64'h55AA, 5'h04, 1, "R4");
    drive(1, 64'h55AA, 64'h55AB, 5'h04, 1, "R4");
    // R7: OR of enabled relations
    drive(1, 64'd9, 64'd2, 5'h18, 1, "R7");
    drive(1, 64'd9, 64'd2, 5'h16, 1, "R7");
    // R8 vs R9: low words equal, upper words differ
    drive(1, 64'h1234_5678_0000_0005, 64'h0000_0000_0000_0005, 5'h04, 0, "R8");
    drive(1, 64'h1234_5678_0000_0005, 64'h0000_0000_0000_0005, 5'h04, 1, "R9");
    // bit 31 set: negative as word, positive as doubleword
    drive(1, 64'h0000_0000_8000_0000, 64'd0, 5'h10, 0, "R8");
    drive(1, 64'h0000_0000_8000_0000, 64'd0, 5'h10, 1, "R9");
    drive(1, 64'h0000_0000_8000_0000, 64'd0, 5'h01, 0, "R8");
    // R10
    drive(1, 64'd4, 64'd9, 5'h00, 1, "R10");
    drive(1, 64'd4, 64'd4, 5'h1F, 0, "R10");
    // R11: strobe low must not trap, back-to-back strobes pulse each
    drive(0, 64'd4, 64'd4, 5'h1F, 1, "R11");
    drive(1, 64'd4, 64'd4, 5'h1F, 1, "R11");
    drive(1, 64'd4, 64'd4, 5'h1F, 1, "R11");
    drive(0, 64'd4, 64'd4, 5'h1F, 1, "R11");
    // mixed patterns
    for (int i = 0; i < 2000; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      case (i % 4)
        0: b = a;
        1: b = {$urandom, a[31:0]};
        2: b = {a[63:32], a[31] ? 32'h7FFF_FFFF : 32'h8000_0000};
        default: ;
      endcase
      drive(($urandom % 5) != 0, a, b, 5'($urandom), 1'($urandom), "R7");
    end
    drive(0, '0, '0, '0, 0, "R11");
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule